// File: doc/BRIEF.md
# Hashed Route Cache with Shadow-Banked Forwarding Table

This block resolves a 32-bit IPv4 destination address into a 64-bit next-hop record. A direct-mapped store of recently used routes is addressed by a short hash of the destination. Each line keeps the full destination beside the route, so a line whose stored destination differs from the request counts as a miss, even when its index matches. A hit answers in one cycle after the request is taken. A miss walks a backing forwarding table one slot per cycle, looking for an exact match. When it finds one, it answers with that route and writes it into the hashed line. When it finds none, it returns a no-route flag and leaves the cache untouched.

The backing table has two banks. Lookups read only the active bank. A management port writes slots of the other bank at any time, including while a lookup is in progress. A swap pulse marks a bank change as pending. The change is carried out in the first idle cycle: the banks trade roles and every cache line is invalidated in the same cycle, so no route from the retired bank can be served after the swap. A lookup already in flight finishes against the bank it started with.

Top module: `route_lookup`

## Requirements
- R1: The cache line index is the XOR of the four address bytes `dst[31:24] ^ dst[23:16] ^ dst[15:8] ^ dst[7:0]`. Two destinations with equal index share one line, and filling one evicts the other.
- R2: A lookup whose line is valid and holds the same destination responds with `rsp_hit`=1, `rsp_noroute`=0 and the cached route. `rsp_valid` rises one cycle after the accepting clock edge.
- R3: A valid line holding a different destination never produces a hit. The request takes the table walk instead.
- R4: On a miss, the active bank is searched for an exact match starting at slot 0. A match at slot i responds 2+i cycles after acceptance, with `rsp_hit`=0, `rsp_noroute`=0 and that slot's route.
- R5: A route found by the walk is written into the hashed line and marked valid, so the next lookup of that destination hits.
- R6: When no valid slot of the active bank matches, the response carries `rsp_noroute`=1 at 1+FIB_DEPTH cycles after acceptance, and nothing is written into the cache.
- R7: Writes through the update port always land in the inactive bank. They never change the result of a lookup until a swap.
- R8: A swap makes the other bank active and invalidates every cache line. While the swap is pending, `req_ready` is low. The swap is applied in the following cycle, and `req_ready` returns high in the cycle after that.
- R9: A swap requested during a lookup is deferred until the lookup has responded. The in-flight lookup uses the old bank, and `req_ready` stays low until the swap is applied.
- R10: `req_ready` is high only when idle. It falls the cycle after a request is accepted, and `rsp_valid` is a single-cycle pulse per request.
- R11: After reset, `rsp_valid` is low, `req_ready` is high, all cache lines are invalid and both banks are empty, so a first lookup returns no-route.
- R12: If several slots of the active bank hold the same destination, the lowest-numbered slot supplies the route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_dst | input | ADDR_W | Destination address to resolve |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from the route cache |
| rsp_noroute | output | 1 | No table entry matched the destination |
| rsp_route | output | ROUTE_W | Next-hop record |
| upd_we | input | 1 | Write one slot of the inactive bank |
| upd_slot | input | SLOT_W | Slot number to write |
| upd_live | input | 1 | Valid bit stored with the slot |
| upd_dst | input | ADDR_W | Destination key stored in the slot |
| upd_route | input | ROUTE_W | Route stored in the slot |
| swap_req | input | 1 | Request to activate the other bank and clear the cache |

## Verification
The bench builds the block with its defaults: a 32-bit address, 64-bit routes, an 8-bit index (256 lines) and an 8-slot table. With an 8-bit index, the hash is the exact byte fold, so the bench can pick an address pair whose bytes fold to the same line and show eviction. With 8 slots, both the earliest match (slot 0) and the full no-route walk finish within a few cycles. Those same values let a duplicate key sit in a later slot, and let a swap be issued in the middle of a lookup that runs the longest walk.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_SCAN = 2'd2
  } lk_state_e;
endpackage

// File: rtl/rc_hash.sv
module rc_hash #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int NCH   = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = NCH * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] fold [NCH];

  always_comb begin
    padded = '0;
    padded[ADDR_W-1:0] = addr;
  end

  assign fold[0] = padded[IDX_W-1:0];
  for (genvar g = 1; g < NCH; g++) begin : g_fold
    assign fold[g] = fold[g-1] ^ padded[g*IDX_W +: IDX_W];
  end

  assign idx = fold[NCH-1];
endmodule

// File: rtl/rc_cache.sv
module rc_cache #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 8,
  parameter int ROUTE_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [ADDR_W-1:0]  rd_tag,
  output logic [ROUTE_W-1:0] rd_route,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [ADDR_W-1:0]  fill_tag,
  input  logic [ROUTE_W-1:0] fill_route,
  input  logic               clr
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]   line_vld, line_vld_nx;
  logic [ADDR_W-1:0]  tag_mem   [LINES];
  logic [ROUTE_W-1:0] route_mem [LINES];

  always_comb begin
    line_vld_nx = line_vld;
    if (clr) begin
      line_vld_nx = '0;
    end else if (fill_en) begin
      line_vld_nx[fill_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_vld <= '0;
    else        line_vld <= line_vld_nx;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_mem[fill_idx]   <= fill_tag;
      route_mem[fill_idx] <= fill_route;
    end
  end

  assign rd_valid = line_vld[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_route = route_mem[rd_idx];

  // R8: an invalidate leaves no line valid
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (line_vld == '0));
  // R5: a fill leaves its line valid
  p_fill_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !clr) |=> line_vld[$past(fill_idx)]);
endmodule

// File: rtl/rc_fib.sv
module rc_fib #(
  parameter int ADDR_W  = 32,
  parameter int ROUTE_W = 64,
  parameter int DEPTH   = 8,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act_bank,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  logic               wr_live,
  input  logic [ADDR_W-1:0]  wr_key,
  input  logic [ROUTE_W-1:0] wr_route,
  input  logic [SLOT_W-1:0]  rd_slot,
  output logic               rd_live,
  output logic [ADDR_W-1:0]  rd_key,
  output logic [ROUTE_W-1:0] rd_route
);
  logic [1:0][DEPTH-1:0] ent_vld, ent_vld_nx;
  logic [ADDR_W-1:0]     key_mem   [2][DEPTH];
  logic [ROUTE_W-1:0]    route_mem [2][DEPTH];
  logic                  wr_bank;

  assign wr_bank = ~act_bank;

  always_comb begin
    ent_vld_nx = ent_vld;
    if (wr_en) ent_vld_nx[wr_bank][wr_slot] = wr_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_vld <= '0;
    else        ent_vld <= ent_vld_nx;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_mem[wr_bank][wr_slot]   <= wr_key;
      route_mem[wr_bank][wr_slot] <= wr_route;
    end
  end

  assign rd_live  = ent_vld[act_bank][rd_slot];
  assign rd_key   = key_mem[act_bank][rd_slot];
  assign rd_route = route_mem[act_bank][rd_slot];

  // R7: without a bank change the active bank's valid bits never move
  p_active_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(act_bank) |-> $stable(ent_vld[act_bank]));
endmodule

// File: rtl/route_lookup.sv
module route_lookup #(
  parameter int ADDR_W    = 32,
  parameter int ROUTE_W   = 64,
  parameter int IDX_W     = 8,
  parameter int FIB_DEPTH = 8,
  localparam int SLOT_W   = $clog2(FIB_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_dst,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_noroute,
  output logic [ROUTE_W-1:0] rsp_route,
  input  logic               upd_we,
  input  logic [SLOT_W-1:0]  upd_slot,
  input  logic               upd_live,
  input  logic [ADDR_W-1:0]  upd_dst,
  input  logic [ROUTE_W-1:0] upd_route,
  input  logic               swap_req
);
  import rc_pkg::*;

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FIB_DEPTH - 1);

  // reset: asynchronous assertion, synchronous release
  logic rst_q1, rst_q2, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q2, rst_q1} <= 2'b00;
    else        {rst_q2, rst_q1} <= {rst_q1, 1'b1};
  end
  assign rst_i = rst_q2;

  lk_state_e          st, st_nx;
  logic [ADDR_W-1:0]  dst_q;
  logic [SLOT_W-1:0]  ptr_q, ptr_nx;
  logic               bank_q, bank_nx;
  logic               pend_q, pend_nx;
  logic               rv_q, rv_nx, hit_q, hit_nx, nr_q, nr_nx;
  logic [ROUTE_W-1:0] route_q, route_nx;
  logic               accept, route_en;

  logic [IDX_W-1:0]   line_idx;
  logic               c_valid, c_hit, fill_en, clr;
  logic [ADDR_W-1:0]  c_tag;
  logic [ROUTE_W-1:0] c_route;
  logic               f_live, f_match;
  logic [ADDR_W-1:0]  f_key;
  logic [ROUTE_W-1:0] f_route;

  rc_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
    .addr (dst_q),
    .idx  (line_idx)
  );

  rc_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ROUTE_W(ROUTE_W)) u_cache (
    .clk        (clk),
    .rst_n      (rst_i),
    .rd_idx     (line_idx),
    .rd_valid   (c_valid),
    .rd_tag     (c_tag),
    .rd_route   (c_route),
    .fill_en    (fill_en),
    .fill_idx   (line_idx),
    .fill_tag   (dst_q),
    .fill_route (f_route),
    .clr        (clr)
  );

  rc_fib #(.ADDR_W(ADDR_W), .ROUTE_W(ROUTE_W), .DEPTH(FIB_DEPTH)) u_fib (
    .clk      (clk),
    .rst_n    (rst_i),
    .act_bank (bank_q),
    .wr_en    (upd_we),
    .wr_slot  (upd_slot),
    .wr_live  (upd_live),
    .wr_key   (upd_dst),
    .wr_route (upd_route),
    .rd_slot  (ptr_q),
    .rd_live  (f_live),
    .rd_key   (f_key),
    .rd_route (f_route)
  );

  assign c_hit     = c_valid && (c_tag == dst_q);
  assign f_match   = f_live && (f_key == dst_q);
  assign req_ready = (st == ST_IDLE) && !pend_q;
  assign accept    = req_ready && req_valid;

  always_comb begin
    st_nx    = st;
    ptr_nx   = ptr_q;
    bank_nx  = bank_q;
    pend_nx  = pend_q | swap_req;
    rv_nx    = 1'b0;
    hit_nx   = hit_q;
    nr_nx    = nr_q;
    route_nx = route_q;
    route_en = 1'b0;
    fill_en  = 1'b0;
    clr      = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (pend_q) begin
          bank_nx = ~bank_q;
          clr     = 1'b1;
          pend_nx = swap_req;
        end else if (req_valid) begin
          st_nx = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (c_hit) begin
          rv_nx    = 1'b1;
          hit_nx   = 1'b1;
          nr_nx    = 1'b0;
          route_nx = c_route;
          route_en = 1'b1;
          st_nx    = ST_IDLE;
        end else begin
          ptr_nx = '0;
          st_nx  = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (f_match) begin
          rv_nx    = 1'b1;
          hit_nx   = 1'b0;
          nr_nx    = 1'b0;
          route_nx = f_route;
          route_en = 1'b1;
          fill_en  = 1'b1;
          st_nx    = ST_IDLE;
        end else if (ptr_q == LAST_SLOT) begin
          rv_nx    = 1'b1;
          hit_nx   = 1'b0;
          nr_nx    = 1'b1;
          route_nx = '0;
          route_en = 1'b1;
          st_nx    = ST_IDLE;
        end else begin
          ptr_nx = ptr_q + 1'b1;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st     <= ST_IDLE;
      ptr_q  <= '0;
      bank_q <= 1'b0;
      pend_q <= 1'b0;
      rv_q   <= 1'b0;
      hit_q  <= 1'b0;
      nr_q   <= 1'b0;
    end else begin
      st     <= st_nx;
      ptr_q  <= ptr_nx;
      bank_q <= bank_nx;
      pend_q <= pend_nx;
      rv_q   <= rv_nx;
      hit_q  <= hit_nx;
      nr_q   <= nr_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (accept)   dst_q   <= req_dst;
    if (route_en) route_q <= route_nx;
  end

  assign rsp_valid   = rv_q;
  assign rsp_hit     = hit_q;
  assign rsp_noroute = nr_q;
  assign rsp_route   = route_q;

  // R2: a tag match in the compare cycle answers on the next edge as a hit
  p_hit_fast_r2: assert property (@(posedge clk) disable iff (!rst_i)
    (st == ST_LOOK && c_hit) |=> (rsp_valid && rsp_hit));
  // R10: accepting a request drops ready
  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_i)
    accept |=> !req_ready);
  // R10: response strobe lasts one cycle
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_i)
    rsp_valid |=> !rsp_valid);
  // R9: the active bank changes only out of the idle state
  p_swap_idle_r9: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(bank_q) |-> ($past(st) == ST_IDLE));
  // R6: a no-route answer is never accompanied by a cache fill
  p_noroute_nofill_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (rv_nx && nr_nx) |-> !fill_en);
endmodule

// File: tb/sim_route_lookup.sv
module sim_route_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int IW         = 8;
  localparam int SW         = $clog2(DEPTH);

  logic          clk, rst_n;
  logic          req_valid, req_ready;
  logic [31:0]   req_dst;
  logic          rsp_valid, rsp_hit, rsp_noroute;
  logic [63:0]   rsp_route;
  logic          upd_we, upd_live, swap_req;
  logic [SW-1:0] upd_slot;
  logic [31:0]   upd_dst;
  logic [63:0]   upd_route;

  route_lookup #(.ADDR_W(32), .ROUTE_W(64), .IDX_W(IW), .FIB_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_dst(req_dst),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_noroute(rsp_noroute),
    .rsp_route(rsp_route),
    .upd_we(upd_we), .upd_slot(upd_slot), .upd_live(upd_live),
    .upd_dst(upd_dst), .upd_route(upd_route), .swap_req(swap_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit          m_live [2][DEPTH];
  logic [31:0] m_key  [2][DEPTH];
  logic [63:0] m_rt   [2][DEPTH];
  int          m_act;
  bit          c_live [256];
  logic [31:0] c_key  [256];
  logic [63:0] c_rt   [256];
  int          nvec, nbad;

  localparam logic [31:0] A = 32'h0A00_0001; // folds to 0x0B
  localparam logic [31:0] B = 32'h0B00_0000; // folds to 0x0B
  localparam logic [31:0] C = 32'hC0A8_0101; // folds to 0x68
  localparam logic [31:0] D = 32'h0102_0304; // folds to 0x04

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int fold(input logic [31:0] a);
    return int'(a[31:24] ^ a[23:16] ^ a[15:8] ^ a[7:0]);
  endfunction

  task automatic upd(input int slot, input bit live, input logic [31:0] k, input logic [63:0] r);
    @(negedge clk);
    upd_we = 1'b1; upd_slot = SW'(slot); upd_live = live; upd_dst = k; upd_route = r;
    @(negedge clk);
    upd_we = 1'b0;
    m_live[1-m_act][slot] = live;
    m_key[1-m_act][slot]  = k;
    m_rt[1-m_act][slot]   = r;
  endtask

  task automatic do_swap();
    @(negedge clk);
    swap_req = 1'b1;
    @(negedge clk);
    swap_req = 1'b0;
    chk("R8 ready low while swap pending", 64'(req_ready), 64'(0));
    m_act = 1 - m_act;
    for (int i = 0; i < 256; i++) c_live[i] = 1'b0;
    @(negedge clk);
    chk("R8 ready back after swap", 64'(req_ready), 64'(1));
  endtask

  task automatic lookup(input logic [31:0] dst, input bit swap_mid, input string tag);
    int h, lat, guard;
    bit ehit, enr;
    logic [63:0] er;
    h = fold(dst);
    ehit = 1'b0; enr = 1'b0; er = '0; lat = 1 + DEPTH;
    if (c_live[h] && c_key[h] == dst) begin
      ehit = 1'b1; lat = 1; er = c_rt[h];
    end else begin
      enr = 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (enr && m_live[m_act][i] && m_key[m_act][i] == dst) begin
          enr = 1'b0; lat = 2 + i; er = m_rt[m_act][i];
        end
      end
      if (!enr) begin
        c_live[h] = 1'b1; c_key[h] = dst; c_rt[h] = er;
      end
    end
    guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b1; req_dst = dst;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R10 ready low when busy"}, 64'(req_ready), 64'(0));
    for (int n = 1; n <= lat; n++) begin
      if (swap_mid && n == 1) swap_req = 1'b1;
      @(negedge clk);
      if (swap_mid && n == 1) swap_req = 1'b0;
      chk({tag, " R10 rsp_valid timing"}, 64'(rsp_valid), 64'(n == lat));
    end
    chk({tag, " R2 hit flag"}, 64'(rsp_hit), 64'(ehit));
    chk({tag, " R6 noroute flag"}, 64'(rsp_noroute), 64'(enr));
    if (!enr) chk({tag, " R4 route"}, rsp_route, er);
    chk({tag, " R9 ready after response"}, 64'(req_ready), 64'(!swap_mid));
    if (swap_mid) begin
      m_act = 1 - m_act;
      for (int i = 0; i < 256; i++) c_live[i] = 1'b0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    nvec = 0; nbad = 0; m_act = 0;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) begin
        m_live[b][i] = 1'b0; m_key[b][i] = '0; m_rt[b][i] = '0;
      end
    for (int i = 0; i < 256; i++) begin
      c_live[i] = 1'b0; c_key[i] = '0; c_rt[i] = '0;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_dst = '0; upd_we = 1'b0; upd_slot = '0;
    upd_live = 1'b0; upd_dst = '0; upd_route = '0; swap_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 rsp_valid low in reset", 64'(rsp_valid), 64'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 ready after reset", 64'(req_ready), 64'(1));
    chk("R11 rsp_valid idle", 64'(rsp_valid), 64'(0));

    lookup(A, 1'b0, "R11 empty tables");
    upd(0, 1'b1, C, 64'hC0C0_0000_0000_0001);
    upd(2, 1'b1, A, 64'hAAAA_0000_0000_0002);
    upd(3, 1'b1, A, 64'hDEAD_0000_0000_0003);
    upd(5, 1'b1, B, 64'hBBBB_0000_0000_0005);
    lookup(A, 1'b0, "R7 inactive writes unseen");
    do_swap();
    lookup(A, 1'b0, "R4 R12 walk to slot 2");
    lookup(A, 1'b0, "R5 R2 refilled hit");
    lookup(B, 1'b0, "R3 R1 same line other tag");
    lookup(A, 1'b0, "R1 evicted by collision");
    lookup(C, 1'b0, "R4 slot 0 match");
    lookup(D, 1'b0, "R6 no route");
    lookup(D, 1'b0, "R6 no fill after no route");
    upd(0, 1'b1, A, 64'h0A0A_1111_2222_3333);
    lookup(A, 1'b0, "R7 cached route kept");
    lookup(C, 1'b0, "R2 hit C");
    lookup(D, 1'b1, "R9 swap mid lookup");
    @(negedge clk);
    chk("R9 ready after deferred swap", 64'(req_ready), 64'(1));
    lookup(A, 1'b0, "R8 new bank after clear");
    lookup(C, 1'b0, "R8 old cache line gone");
    lookup(A, 1'b0, "R5 hit in new bank");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule